// File: doc/BRIEF.md
# Keyed Write Window for NAND Control Registers

This block watches a 16-bit synchronous write bus (strobe, address, data) and protects a small group of control registers behind a key. A host opens a write window by issuing four writes in a fixed order: an alternating pair of data values, each sent to its own key address. Only while the window is open do writes to the protected registers change them. A closing value written to a dedicated lock address shuts the window again.

The protected registers are a global enable flag, a NAND access gate and a two-bit NAND pin register. The pin register drives the active-low chip-enable and write-protect outputs. The access gate drives a flag that tells downstream logic whether NAND access is allowed. All addresses are parameters. Writes to addresses the block does not decode are ignored and leave the key tracker alone.

Top module: `nand_key_gate`

## Requirements
- R1: After reset the window is closed, the NAND access flag and the global enable are low, and both NAND pin outputs are 0.
- R2: Four consecutive decoded key writes, 0xD200 to KEY_A, then 0x1500 to KEY_B, then 0xD200 to KEY_C, then 0x1500 to KEY_D, open the window. `win_open_o` is high in the cycle after the fourth write.
- R3: A write to any key address with the wrong address or value for the current step sends the tracker back to idle. A write of 0xD200 to KEY_A always restarts the tracker at step 1, even partway through a sequence.
- R4: Writes to addresses that are neither key addresses nor the lock address leave the tracker's progress unchanged.
- R5: Writing 0x1500 to LOCK_ADDR closes the window in the next cycle. Any other value written to LOCK_ADDR has no effect.
- R6: While the window is closed, writes to the protected registers leave every output unchanged.
- R7: While the window is open, 0x1500 written to NLOCK_ADDR raises `nand_ok_o` and 0xD200 lowers it. Other values are ignored.
- R8: While the window is open, a write to NEN_ADDR loads data bits [1:0]. Bit 0 drives `nand_ce_n_o` and bit 1 drives `nand_wp_n_o`. Values 0, 1 and 3 therefore give pin levels (0,0), (1,0) and (1,1).
- R9: While the window is open, 0x8000 written to GLOB_ADDR sets `glob_en_o`. Other values are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe, one write per cycle |
| wr_addr_i | input | ADDR_W | Write address |
| wr_data_i | input | 16 | Write data |
| win_open_o | output | 1 | Write window open |
| nand_ok_o | output | 1 | NAND access allowed |
| glob_en_o | output | 1 | Global enable flag |
| nand_ce_n_o | output | 1 | NAND chip enable, active low |
| nand_wp_n_o | output | 1 | NAND write protect, active low |

## Verification
The key tracker is tested with four kinds of sequence. A clean sequence must open the window. A sequence with one wrong value must not, which shows that values are compared and not only addresses. A sequence with a repeated first step must still open the window, which shows the restart path. A sequence with unrelated writes between the steps must also open it, which shows that unrelated addresses are ignored. Protected writes are issued before the key, inside the window and after the lock write, so that any gating fault appears as a changed output. Each NAND gate value and pin encoding is driven in turn, including values that must be ignored.

// File: rtl/nand_key_gate_pkg.sv
package nand_key_gate_pkg;
  localparam int unsigned DATA_W = 16;
  localparam logic [DATA_W-1:0] KEY_LO   = 16'hD200;
  localparam logic [DATA_W-1:0] KEY_HI   = 16'h1500;
  localparam logic [DATA_W-1:0] GLOB_SET = 16'h8000;
  localparam int unsigned STEPS  = 4;
  localparam int unsigned STEP_W = $clog2(STEPS);
endpackage

// File: rtl/key_seq.sv
module key_seq
  import nand_key_gate_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter logic [ADDR_W-1:0] KEY_A = '0,
  parameter logic [ADDR_W-1:0] KEY_B = '0,
  parameter logic [ADDR_W-1:0] KEY_C = '0,
  parameter logic [ADDR_W-1:0] KEY_D = '0,
  parameter logic [ADDR_W-1:0] LOCK_ADDR = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              win_o
);
  localparam logic [STEP_W-1:0] LAST = STEP_W'(STEPS - 1);

  logic [STEP_W-1:0] step_q, step_d;
  logic              win_q, win_d;
  logic              is_key, match, restart, fire, lock_hit;
  logic [ADDR_W-1:0] exp_addr;
  logic [DATA_W-1:0] exp_data;

  always_comb begin
    unique case (step_q)
      2'd0:    begin exp_addr = KEY_A; exp_data = KEY_LO; end
      2'd1:    begin exp_addr = KEY_B; exp_data = KEY_HI; end
      2'd2:    begin exp_addr = KEY_C; exp_data = KEY_LO; end
      default: begin exp_addr = KEY_D; exp_data = KEY_HI; end
    endcase
  end

  assign is_key   = (wr_addr_i == KEY_A) || (wr_addr_i == KEY_B) ||
                    (wr_addr_i == KEY_C) || (wr_addr_i == KEY_D);
  assign match    = (wr_addr_i == exp_addr) && (wr_data_i == exp_data);
  assign restart  = (wr_addr_i == KEY_A) && (wr_data_i == KEY_LO);
  assign lock_hit = wr_en_i && (wr_addr_i == LOCK_ADDR) && (wr_data_i == KEY_HI);

  always_comb begin
    step_d = step_q;
    fire   = 1'b0;
    if (wr_en_i && is_key) begin
      if (match) begin
        if (step_q == LAST) begin
          step_d = '0;
          fire   = 1'b1;
        end else begin
          step_d = step_q + 1'b1;
        end
      end else if (restart) begin
        step_d = STEP_W'(1);
      end else begin
        step_d = '0;
      end
    end
    win_d = win_q;
    if (fire)          win_d = 1'b1;
    else if (lock_hit) win_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q <= '0;
      win_q  <= 1'b0;
    end else begin
      step_q <= step_d;
      win_q  <= win_d;
    end
  end

  assign win_o = win_q;

  // R2
  win_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(win_q) |-> $past(wr_en_i && wr_addr_i == KEY_D && wr_data_i == KEY_HI && step_q == LAST));
  // R5
  win_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(win_q) |-> $past(wr_en_i && wr_addr_i == LOCK_ADDR && wr_data_i == KEY_HI));
  // R3
  step_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && is_key && !match && !restart) |=> (step_q == '0));
  // R4
  step_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_en_i || !is_key) |=> $stable(step_q));
endmodule

// File: rtl/prot_regs.sv
module prot_regs
  import nand_key_gate_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter logic [ADDR_W-1:0] GLOB_ADDR  = '0,
  parameter logic [ADDR_W-1:0] NLOCK_ADDR = '0,
  parameter logic [ADDR_W-1:0] NEN_ADDR   = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              win_i,
  output logic              nand_ok_o,
  output logic              glob_en_o,
  output logic              ce_n_o,
  output logic              wp_n_o
);
  logic       wr_ok;
  logic       ok_q, glob_q;
  logic [1:0] pins_q;

  assign wr_ok = wr_en_i && win_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ok_q   <= 1'b0;
      glob_q <= 1'b0;
      pins_q <= 2'b00;
    end else if (wr_ok) begin
      if (wr_addr_i == NLOCK_ADDR) begin
        if (wr_data_i == KEY_HI)      ok_q <= 1'b1;
        else if (wr_data_i == KEY_LO) ok_q <= 1'b0;
      end
      if (wr_addr_i == GLOB_ADDR && wr_data_i == GLOB_SET) glob_q <= 1'b1;
      if (wr_addr_i == NEN_ADDR) pins_q <= wr_data_i[1:0];
    end
  end

  assign nand_ok_o = ok_q;
  assign glob_en_o = glob_q;
  assign ce_n_o    = pins_q[0];
  assign wp_n_o    = pins_q[1];

  // R6
  closed_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !win_i |=> $stable({ok_q, glob_q, pins_q}));
  // R7
  ok_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(ok_q) |-> $past(wr_ok && wr_addr_i == NLOCK_ADDR));
  // R9
  glob_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(glob_q) |-> $past(wr_ok && wr_addr_i == GLOB_ADDR && wr_data_i == GLOB_SET));
  // R8
  pins_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(pins_q) |-> $past(wr_ok && wr_addr_i == NEN_ADDR));
endmodule

// File: rtl/nand_key_gate.sv
module nand_key_gate
  import nand_key_gate_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter logic [ADDR_W-1:0] KEY_A      = 16'hFF00,
  parameter logic [ADDR_W-1:0] KEY_B      = 16'h0000,
  parameter logic [ADDR_W-1:0] KEY_C      = 16'h0100,
  parameter logic [ADDR_W-1:0] KEY_D      = 16'h0200,
  parameter logic [ADDR_W-1:0] LOCK_ADDR  = 16'hFE00,
  parameter logic [ADDR_W-1:0] GLOB_ADDR  = 16'hC400,
  parameter logic [ADDR_W-1:0] NLOCK_ADDR = 16'hE200,
  parameter logic [ADDR_W-1:0] NEN_ADDR   = 16'hA000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              win_open_o,
  output logic              nand_ok_o,
  output logic              glob_en_o,
  output logic              nand_ce_n_o,
  output logic              nand_wp_n_o
);
  logic win;

  key_seq #(
    .ADDR_W(ADDR_W), .KEY_A(KEY_A), .KEY_B(KEY_B), .KEY_C(KEY_C),
    .KEY_D(KEY_D), .LOCK_ADDR(LOCK_ADDR)
  ) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i),
    .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i), .win_o(win)
  );

  prot_regs #(
    .ADDR_W(ADDR_W), .GLOB_ADDR(GLOB_ADDR), .NLOCK_ADDR(NLOCK_ADDR),
    .NEN_ADDR(NEN_ADDR)
  ) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i),
    .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i), .win_i(win),
    .nand_ok_o(nand_ok_o), .glob_en_o(glob_en_o),
    .ce_n_o(nand_ce_n_o), .wp_n_o(nand_wp_n_o)
  );

  assign win_open_o = win;

  // R1
  reset_state_chk: assert property (@(posedge clk_i)
    !rst_ni |-> (!win_open_o && !nand_ok_o && !glob_en_o && !nand_ce_n_o && !nand_wp_n_o));
endmodule

// File: tb/nand_key_gate_tb.sv
module nand_key_gate_tb;
  localparam logic [15:0] A = 16'hFF00, B = 16'h0000, C = 16'h0100, D = 16'h0200;
  localparam logic [15:0] LK = 16'hFE00, GL = 16'hC400, NL = 16'hE200, NE = 16'hA000;
  localparam logic [15:0] LO = 16'hD200, HI = 16'h1500;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [15:0] wr_addr = '0, wr_data = '0;
  logic win, ok, glob, ce_n, wp_n;
  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  nand_key_gate u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .win_open_o(win), .nand_ok_o(ok), .glob_en_o(glob),
    .nand_ce_n_o(ce_n), .nand_wp_n_o(wp_n)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic key();
    wr(A, LO); wr(B, HI); wr(C, LO); wr(D, HI);
  endtask

  function automatic logic [7:0] outs();
    return {3'b0, win, ok, glob, wp_n, ce_n};
  endfunction

  task automatic t_reset();
    check("R1 reset outputs", outs(), 8'h00);
  endtask

  task automatic t_closed();
    wr(NE, 16'h0003); wr(NL, HI); wr(GL, 16'h8000);
    check("R6 protected writes before key", outs(), 8'h00);
  endtask

  task automatic t_key_bad();
    wr(A, LO); wr(B, HI); wr(C, HI); wr(D, HI);
    check("R3 wrong value keeps window shut", {7'b0, win}, 8'h00);
    wr(A, LO); wr(B, LO); wr(C, LO); wr(D, HI);
    check("R3 wrong B value resets tracker", {7'b0, win}, 8'h00);
  endtask

  task automatic t_restart();
    wr(A, LO); wr(B, HI); wr(A, LO); wr(B, HI); wr(C, LO);
    check("R2 window shut before step 4", {7'b0, win}, 8'h00);
    wr(D, HI);
    check("R3 restart then full key opens", {7'b0, win}, 8'h01);
    wr(LK, HI);
    check("R5 lock closes window", {7'b0, win}, 8'h00);
  endtask

  task automatic t_noise();
    wr(A, LO); wr(16'h5555, 16'h1234); wr(B, HI); wr(C, LO);
    wr(16'h7777, LO); wr(D, HI);
    check("R4 unrelated writes between steps", {7'b0, win}, 8'h01);
  endtask

  task automatic t_open_regs();
    wr(NL, HI);          check("R7 grant", {7'b0, ok}, 8'h01);
    wr(NL, 16'h1234);    check("R7 other value ignored", {7'b0, ok}, 8'h01);
    wr(NL, LO);          check("R7 revoke", {7'b0, ok}, 8'h00);
    wr(NL, HI);          check("R7 grant again", {7'b0, ok}, 8'h01);
    wr(NE, 16'h0001);    check("R8 value 1", {6'b0, wp_n, ce_n}, 8'h01);
    wr(NE, 16'h0003);    check("R8 value 3", {6'b0, wp_n, ce_n}, 8'h03);
    wr(NE, 16'h0000);    check("R8 value 0", {6'b0, wp_n, ce_n}, 8'h00);
    wr(GL, 16'h4000);    check("R9 other value ignored", {7'b0, glob}, 8'h00);
    wr(GL, 16'h8000);    check("R9 set", {7'b0, glob}, 8'h01);
    wr(NE, 16'h0003);
  endtask

  task automatic t_lock();
    wr(LK, 16'h1234);
    check("R5 wrong lock value ignored", {7'b0, win}, 8'h01);
    wr(LK, HI);
    check("R5 lock closes", {7'b0, win}, 8'h00);
    wr(NE, 16'h0000); wr(NL, LO);
    check("R6 writes after lock ignored", outs(), 8'h0F);
    key();
    check("R2 reopen after lock", {7'b0, win}, 8'h01);
  endtask

  initial begin
    #20_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_closed();
    t_key_bad();
    t_restart();
    t_noise();
    t_open_regs();
    t_lock();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule